// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block lets an external two-wire bus master read and write a small bank of 8-bit configuration registers. Both bus lines are sampled with the system clock through two-flop synchronizers. The block detects START, repeated START and STOP conditions and answers only to a fixed 7-bit device address. Its only output onto the bus is an active-high enable for an open-drain pull-down on SDA. The register contents are also presented as one flat parallel vector, so that nearby logic can use them directly.

In a write frame, the first byte after the address loads an internal register pointer. Each following byte is stored at that pointer, and the pointer then advances by one. In a read frame, the block returns bytes starting at the current pointer and advances it after each byte. The master continues a read by acknowledging each byte and ends it with a NACK. To read a chosen register, the master writes the pointer, issues a repeated START, and then sends the read address.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset, every register reads 0x00 and the SDA pull-down enable is low.
- R2: The byte 0x9A (write) or 0x9B (read), which is device address 1001101 sent MSB first followed by the R/W bit, is acknowledged by holding SDA low through the ninth SCL high. Any other address byte is not acknowledged, and the block ignores all traffic until the next START.
- R3: In a write frame, the first byte after the address loads the register pointer and is acknowledged.
- R4: Every later byte of a write frame is acknowledged and stored in the register the pointer selects. The pointer then increases by one.
- R5: A data byte written while the pointer is above 0x09 is acknowledged, changes no register, and still advances the pointer.
- R6: A read frame shifts out, MSB first, the register at the pointer and advances the pointer after each byte. Pointer values above 0x09 return 0x00.
- R7: A master ACK after a read byte makes the block send the next byte. A master NACK makes it release SDA and ignore further clocks until the next START.
- R8: A STOP at any point, including in the middle of a byte, ends the frame. The register pointer keeps its value.
- R9: A STOP that falls within the same SCL high period as a START is ignored, and the frame continues with the address byte.
- R10: A repeated START restarts the address phase without disturbing the pointer, so a pointer write followed by a repeated START and a read address returns the selected register.
- R11: The block changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | High enables the open-drain pull-down on SDA |
| regs_o | output | NREGS*8 | Register contents; register i sits at bits 8*i+7 down to 8*i |

## Verification
Condition detection and bit sampling can fall in the same SCL high period. This happens when a START and a STOP share one high pulse, or when a STOP arrives while a byte is still being shifted. The bench provokes the first case by raising SDA again before SCL falls after a START. It passes only if the following address byte is still acknowledged and its write lands. The second case is provoked by a STOP after four address bits, and it passes only if a clean frame that follows is acknowledged.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_ACK,
        PH_TX,
        PH_MACK
    } phase_e;

    typedef enum logic [1:0] {
        BY_ADDR,
        BY_PTR,
        BY_DATA
    } byte_e;

    typedef struct packed {
        phase_e      phase;
        byte_e       kind;
        logic        rd;
        logic [3:0]  bits;
        logic [7:0]  sh;
        logic [7:0]  ptr;
        logic        pull;
        logic        st_hi;
        logic        we;
        logic [7:0]  wa;
        logic [7:0]  wd;
    } eng_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o,
    output logic [LINES-1:0] prv_o
);
    localparam int DEPTH = STAGES + 1;

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [DEPTH-1:0] chain_q;
        logic [DEPTH-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[DEPTH-2:0], raw_i[l]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign lvl_o[l] = chain_q[STAGES-1];
        assign prv_o[l] = chain_q[STAGES];
    end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int NREGS = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [7:0]         wa_i,
    input  logic [7:0]         wd_i,
    input  logic [7:0]         rd_idx_i,
    output logic [7:0]         rd_data_o,
    output logic [NREGS*8-1:0] regs_o
);
    logic [7:0] cells [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_cell
        logic [7:0] cell_q;
        logic [7:0] cell_d;

        always_comb begin
            cell_d = cell_q;
            if (we_i && wa_i == 8'(g)) cell_d = wd_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cell_q <= '0;
            else        cell_q <= cell_d;
        end

        assign cells[g]          = cell_q;
        assign regs_o[g*8 +: 8]  = cell_q;

        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && wa_i == 8'(g)) |=> (cell_q == $past(wd_i))); // R4
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (rd_idx_i == 8'(i)) rd_data_o = cells[i];
        end
    end

    AST_RESERVED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wa_i >= 8'(NREGS)) |=> $stable(regs_o)); // R5

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1001101,
    parameter int         NREGS    = 10,
    parameter int         STAGES   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    output logic [NREGS*8-1:0] regs_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] lvl, prv;
    logic             scl, scl_p, sda, sda_p;
    logic             scl_rise, scl_fall, start_c, stop_c;
    logic [7:0]       rd_data;
    eng_t             q, d;

    i2c_line_sync #(.LINES(LINES), .STAGES(STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({sda_i, scl_i}),
        .lvl_o (lvl),
        .prv_o (prv)
    );

    assign scl   = lvl[0];
    assign scl_p = prv[0];
    assign sda   = lvl[1];
    assign sda_p = prv[1];

    assign scl_rise = scl & ~scl_p;
    assign scl_fall = ~scl & scl_p;
    assign start_c  = scl & scl_p & sda_p & ~sda;
    assign stop_c   = scl & scl_p & ~sda_p & sda;

    i2c_reg_bank #(.NREGS(NREGS)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (q.we),
        .wa_i      (q.wa),
        .wd_i      (q.wd),
        .rd_idx_i  (q.ptr),
        .rd_data_o (rd_data),
        .regs_o    (regs_o)
    );

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (scl_fall) d.st_hi = 1'b0;

        if (start_c) begin
            d.phase = PH_RX;
            d.kind  = BY_ADDR;
            d.bits  = '0;
            d.pull  = 1'b0;
            d.rd    = 1'b0;
            d.st_hi = 1'b1;
        end else if (stop_c && !q.st_hi) begin
            d.phase = PH_IDLE;
            d.pull  = 1'b0;
        end else begin
            unique case (q.phase)
                PH_RX: begin
                    if (scl_rise && q.bits != 4'd8) begin
                        d.sh   = {q.sh[6:0], sda};
                        d.bits = q.bits + 4'd1;
                    end else if (scl_fall && q.bits == 4'd8) begin
                        unique case (q.kind)
                            BY_ADDR: begin
                                if (q.sh[7:1] == DEV_ADDR) begin
                                    d.pull  = 1'b1;
                                    d.rd    = q.sh[0];
                                    d.phase = PH_ACK;
                                end else begin
                                    d.phase = PH_IDLE;
                                end
                            end
                            BY_PTR: begin
                                d.ptr   = q.sh;
                                d.pull  = 1'b1;
                                d.phase = PH_ACK;
                            end
                            default: begin
                                d.we    = 1'b1;
                                d.wa    = q.ptr;
                                d.wd    = q.sh;
                                d.ptr   = q.ptr + 8'd1;
                                d.pull  = 1'b1;
                                d.phase = PH_ACK;
                            end
                        endcase
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        d.bits = '0;
                        if (q.rd) begin
                            d.sh    = rd_data;
                            d.pull  = ~rd_data[7];
                            d.ptr   = q.ptr + 8'd1;
                            d.phase = PH_TX;
                        end else begin
                            d.pull  = 1'b0;
                            d.phase = PH_RX;
                            d.kind  = (q.kind == BY_ADDR) ? BY_PTR : BY_DATA;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (q.bits == 4'd7) begin
                            d.pull  = 1'b0;
                            d.phase = PH_MACK;
                        end else begin
                            d.bits = q.bits + 4'd1;
                            d.pull = ~q.sh[6];
                            d.sh   = {q.sh[6:0], 1'b0};
                        end
                    end
                end
                PH_MACK: begin
                    if (scl_rise && sda) begin
                        d.phase = PH_IDLE;
                    end else if (scl_fall) begin
                        d.bits  = '0;
                        d.sh    = rd_data;
                        d.pull  = ~rd_data[7];
                        d.ptr   = q.ptr + 8'd1;
                        d.phase = PH_TX;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
            q.kind  <= BY_ADDR;
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o = q.pull;

    AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl && scl_p && sda == sda_p) |=> $stable(q.pull)); // R11
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_IDLE) |-> !sda_pull_o); // R2
    AST_NACK_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_MACK && scl_rise && sda && !start_c && !stop_c) |=> (q.phase == PH_IDLE)); // R7
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_ACK) |-> sda_pull_o); // R2
    AST_WRITE_STEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |-> (q.ptr == q.wa + 8'd1)); // R4

endmodule

// File: tb/test_i2c_cfg_slave.sv
module test_i2c_cfg_slave;
    localparam int NREGS = 10;
    localparam int Q     = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               scl = 1'b1;
    logic               sda_m = 1'b1;
    logic               sda_bus;
    logic               pull;
    logic [NREGS*8-1:0] regs;
    logic [7:0]         model [NREGS];
    int                 checks = 0;
    int                 fails = 0;
    int                 hold_bad = 0;
    bit                 done = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~pull;

    i2c_cfg_slave #(.NREGS(NREGS)) i_i2c_cfg_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .sda_pull_o (pull),
        .regs_o     (regs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_bank(input string req);
        for (int i = 0; i < NREGS; i++) begin
            chk(req, {24'd0, regs[i*8 +: 8]}, {24'd0, model[i]});
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; waitq();
        scl = 1'b1; waitq(); waitq();
        scl = 1'b0; waitq();
    endtask

    task automatic bit_in(output logic r);
        logic late;
        sda_m = 1'b1; waitq();
        scl = 1'b1; waitq();
        r = sda_bus; waitq();
        late = sda_bus;
        if (late !== r) hold_bad++;
        scl = 1'b0; waitq();
    endtask

    task automatic byte_out(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic byte_in(input logic mack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) bit_in(v[i]);
        bit_out(~mack);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq();
        scl = 1'b1; waitq();
        sda_m = 1'b0; waitq();
        scl = 1'b0; waitq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq();
        scl = 1'b1; waitq();
        sda_m = 1'b1; waitq();
    endtask

    task automatic t_reset();
        chk("R1 pull", {31'd0, pull}, 32'd0);
        chk_bank("R1 regs");
    endtask

    task automatic t_single_write();
        logic a;
        bus_start();
        byte_out(8'h9A, a); chk("R2 write address ack", {31'd0, a}, 32'd1);
        byte_out(8'h03, a); chk("R3 pointer ack", {31'd0, a}, 32'd1);
        byte_out(8'hA5, a); chk("R4 data ack", {31'd0, a}, 32'd1);
        bus_stop();
        model[3] = 8'hA5;
        chk_bank("R4 single write");
    endtask

    task automatic t_burst_reserved();
        logic a;
        bus_start();
        byte_out(8'h9A, a);
        byte_out(8'h07, a);
        byte_out(8'h11, a); chk("R4 burst ack 7", {31'd0, a}, 32'd1);
        byte_out(8'h22, a); chk("R4 burst ack 8", {31'd0, a}, 32'd1);
        byte_out(8'h33, a); chk("R4 burst ack 9", {31'd0, a}, 32'd1);
        byte_out(8'h44, a); chk("R5 reserved ack", {31'd0, a}, 32'd1);
        bus_stop();
        model[7] = 8'h11; model[8] = 8'h22; model[9] = 8'h33;
        chk_bank("R5 burst then reserved");
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start();
        byte_out(8'h90, a); chk("R2 foreign address nack", {31'd0, a}, 32'd0);
        byte_out(8'h05, a); chk("R2 ignored byte nack", {31'd0, a}, 32'd0);
        byte_out(8'h66, a); chk("R2 ignored data nack", {31'd0, a}, 32'd0);
        bus_stop();
        chk_bank("R2 bank untouched");
    endtask

    task automatic t_read_repeated_start();
        logic       a;
        logic [7:0] v;
        bus_start();
        byte_out(8'h9A, a);
        byte_out(8'h07, a);
        bus_start();
        byte_out(8'h9B, a); chk("R10 read address after repeated start", {31'd0, a}, 32'd1);
        byte_in(1'b1, v); chk("R10 first read", {24'd0, v}, 32'h11);
        byte_in(1'b1, v); chk("R6 second read", {24'd0, v}, 32'h22);
        byte_in(1'b1, v); chk("R6 third read", {24'd0, v}, 32'h33);
        byte_in(1'b0, v); chk("R6 reserved read", {24'd0, v}, 32'h00);
        bus_stop();
    endtask

    task automatic t_nack_release();
        logic       a;
        logic [7:0] v;
        bus_start();
        byte_out(8'h9A, a);
        byte_out(8'h03, a);
        bus_start();
        byte_out(8'h9B, a);
        byte_in(1'b0, v); chk("R6 read at pointer", {24'd0, v}, 32'hA5);
        byte_in(1'b1, v); chk("R7 released after nack", {24'd0, v}, 32'hFF);
        bus_stop();
    endtask

    task automatic t_stop_keeps_ptr();
        logic       a;
        logic [7:0] v;
        bus_start();
        byte_out(8'h9A, a);
        byte_out(8'h08, a);
        bus_stop();
        bus_start();
        byte_out(8'h9B, a); chk("R8 read frame ack", {31'd0, a}, 32'd1);
        byte_in(1'b0, v); chk("R8 pointer kept over stop", {24'd0, v}, 32'h22);
        bus_stop();
        bus_start();
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b0); bit_out(1'b1);
        bus_stop();
        bus_start();
        byte_out(8'h9A, a); chk("R8 clean frame after mid-byte stop", {31'd0, a}, 32'd1);
        bus_stop();
    endtask

    task automatic t_start_stop_same_high();
        logic a;
        sda_m = 1'b1; scl = 1'b1; waitq();
        sda_m = 1'b0; waitq();
        sda_m = 1'b1; waitq();
        scl = 1'b0; waitq();
        byte_out(8'h9A, a); chk("R9 address after start-stop pulse", {31'd0, a}, 32'd1);
        byte_out(8'h01, a);
        byte_out(8'h5A, a);
        bus_stop();
        model[1] = 8'h5A;
        chk_bank("R9 frame continued");
    endtask

    initial begin
        for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_single_write();
        t_burst_reserved();
        t_mismatch();
        t_read_repeated_start();
        t_nack_release();
        t_stop_keeps_ptr();
        t_start_stop_same_high();
        chk("R11 slave data steady in SCL high", hold_bad, 32'd0);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule